// File: doc/BRIEF.md
# Bridge Fault Monitor and Diagnosis Status

This block watches the protection comparators of a two-output power bridge. It decides when a switch-current event is a real short, latches short and overtemperature faults, and follows the supply undervoltage state. It also counts PWM pulses to find an open load while the bridge is switching, and takes the open-load comparator that is valid while the bridge is off. From all of this it builds one status byte for a serial diagnosis reader. It drives a shutdown request to the switch controller and an error flag that is high whenever the outputs are off.

Every input is a synchronous, already filtered digital flag in the block's clock domain. The enable state is the combined result of the disable pin and the serial enable bit. Any toggle of it counts as an enable reset of the diagnosis. A serial reset-diagnosis command and a supply/sleep reset arrive as single-cycle pulses.

Top module: `hbridge_diag`

## Requirements
- R1: After reset the status byte is 0xDF, and shutdown_req and err_flag are low while bridge_en is high.
- R2: A switch-current flag counts as a short only after it has been high on FILT_CYC consecutive clock edges. A shorter run latches nothing. A high-side flag means short to ground and a low-side flag means short to supply on that output.
- R3: The fault code in status[3:0] starts at 0xF, and each latched short clears one bit: bit0 for ground short on output 1, bit1 for supply short on output 1, bit2 for ground short on output 2, bit3 for supply short on output 2. Shorts on different outputs therefore combine.
- R4: Each output holds at most one short kind. The first kind latched wins, and if both kinds qualify in the same cycle the ground short wins.
- R5: A latched short raises shutdown_req and stays after the flag drops. It is cleared only by a toggle of bridge_en, a diag_clr pulse or a supply_rst pulse.
- R6: ot_shut latches an overtemperature fault that clears status[6] and raises shutdown_req. It stays until ot_cool is seen while ot_shut is low.
- R7: Undervoltage raises shutdown_req and sets code 0x3 one cycle after uv rises. It does not latch: both go away one cycle after uv falls.
- R8: Open load while switching (code 0xC) is reported after PULSES pwm_pulse strobes without fw_seen. It clears after PULSES consecutive strobes with fw_seen, or on a change of dir.
- R9: While the bridge is disabled, a high ol_off_cmp reports code 0xC.
- R10: While ol_dis is high, code 0xC is never reported, whether from open load while switching or from open load while off.
- R11: cur_lim clears status[4] from the next cycle on. The indication holds until dir changes or a diagnosis reset occurs, with an active cur_lim taking priority.
- R12: Code priority: latched shorts above undervoltage, undervoltage above open load.
- R13: err_flag is high when shutdown_req is high or the bridge is disabled. status[7] shows the registered enable state.
- R14: status[5] is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_short | input | 2 | High-side over-threshold flag per output (bit0 = output 1) |
| ls_short | input | 2 | Low-side over-threshold flag per output |
| cur_lim | input | 1 | Chopper current limit active |
| ot_shut | input | 1 | Junction above shutdown temperature |
| ot_cool | input | 1 | Junction below switch-on temperature |
| uv | input | 1 | Supply below the off threshold |
| ol_off_cmp | input | 1 | Open-load comparator, valid while disabled |
| pwm_pulse | input | 1 | One-cycle strobe per PWM pulse |
| fw_seen | input | 1 | Freewheeling detected in this pulse, valid with pwm_pulse |
| bridge_en | input | 1 | Combined enable state of the bridge |
| dir | input | 1 | Direction input |
| ol_dis | input | 1 | Open-load diagnosis disabled |
| diag_clr | input | 1 | Reset-diagnosis command pulse |
| supply_rst | input | 1 | Power-on or sleep reset pulse |
| shutdown_req | output | 1 | Turn all bridge switches off |
| err_flag | output | 1 | Outputs are off, by fault or by disable |
| status | output | 8 | Diagnosis status byte |

## Verification
The checker assumes every input changes only between clock edges, with pwm_pulse lasting one cycle and diag_clr and supply_rst lasting one cycle. It also assumes fw_seen is only meaningful alongside a strobe. The bench drives every input just after the falling edge, and it holds each short flag high for an exact count of edges. The bench never raises ot_shut and ot_cool together. Checks are made at the falling edge, so all registered state has settled by then.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
    // Fault code values shown in the low nibble of the status byte
    localparam logic [3:0] CODE_NONE = 4'hF;
    localparam logic [3:0] CODE_OL   = 4'hC;
    localparam logic [3:0] CODE_UV   = 4'h3;

    // Status byte bit positions
    localparam int unsigned ST_EN = 7;
    localparam int unsigned ST_OT = 6;
    localparam int unsigned ST_TV = 5;
    localparam int unsigned ST_CL = 4;

    // Shorts clear one code bit each; the priority is shorts, then undervoltage, then open load.
    function automatic logic [3:0] fault_code(input logic [1:0] scg,
                                              input logic [1:0] scvs,
                                              input logic       uv_act,
                                              input logic       ol_act);
        logic [3:0] sc_bits;
        sc_bits = {scvs[1], scg[1], scvs[0], scg[0]};
        if (|sc_bits)
            fault_code = ~sc_bits;
        else if (uv_act)
            fault_code = CODE_UV;
        else if (ol_act)
            fault_code = CODE_OL;
        else
            fault_code = CODE_NONE;
    endfunction
endpackage

// File: rtl/hbd_short_filter.sv
// Short filter for one switch current flag.
// Counts consecutive clock edges on which the flag is high, and signals a
// detection on the edge where the run reaches FILT_CYC.
// Assumes the flag is synchronous to clk.
module hbd_short_filter #(
    parameter int unsigned FILT_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    output logic det
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] run_q;

    // Length of the current run of high samples, held at its limit
    always_ff @(posedge clk) begin
        if (!rst_n || !flag)
            run_q <= '0;
        else if (run_q != LAST)
            run_q <= run_q + 1'b1;
    end

    assign det = flag && (run_q == LAST);
endmodule

// File: rtl/hbd_short_latch.sv
// Latches shorts to ground and to supply for each bridge output.
// Each output keeps only one short kind; the first one wins and ground wins
// when both kinds qualify together. A clear pulse empties all latches.
module hbd_short_latch #(
    parameter int unsigned N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] det_hs,
    input  logic [N_OUT-1:0] det_ls,
    input  logic             clr,
    output logic [N_OUT-1:0] scg,
    output logic [N_OUT-1:0] scvs
);
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        // Ground-short latch for output k
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                scg[k] <= 1'b0;
            else if (det_hs[k] && !scvs[k])
                scg[k] <= 1'b1;
        end

        // Supply-short latch for output k
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                scvs[k] <= 1'b0;
            else if (det_ls[k] && !det_hs[k] && !scg[k])
                scvs[k] <= 1'b1;
        end
    end
endmodule

// File: rtl/hbd_openload_on.sv
// Open-load detection while the bridge switches.
// Reports after PULSES strobes with no freewheeling, and withdraws after
// PULSES consecutive strobes with freewheeling. clr restarts everything.
// Assumes pulse is a one-cycle strobe and fw is valid with it.
module hbd_openload_on #(
    parameter int unsigned PULSES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    input  logic fw,
    input  logic clr,
    output logic ol
);
    localparam int unsigned CW = $clog2(PULSES + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSES - 1);

    logic [CW-1:0] miss_q;
    logic [CW-1:0] hit_q;

    // Strobes without freewheeling seen since the last freewheel
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            miss_q <= '0;
        else if (pulse) begin
            if (fw)
                miss_q <= '0;
            else if (miss_q != LAST)
                miss_q <= miss_q + 1'b1;
        end
    end

    // Consecutive strobes with freewheeling
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            hit_q <= '0;
        else if (pulse) begin
            if (!fw)
                hit_q <= '0;
            else if (hit_q != LAST)
                hit_q <= hit_q + 1'b1;
        end
    end

    // Open-load indication with set and auto-clear thresholds
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ol <= 1'b0;
        else if (pulse && !fw && miss_q == LAST)
            ol <= 1'b1;
        else if (pulse && fw && hit_q == LAST)
            ol <= 1'b0;
    end
endmodule

// File: rtl/hbridge_diag.sv
// Bridge fault monitor: filters shorts, latches shorts and overtemperature,
// tracks undervoltage, open load and current limit, and forms the status
// byte, the shutdown request and the error flag.
// Assumes all inputs are synchronous to clk; diag_clr and supply_rst are pulses.
module hbridge_diag #(
    parameter int unsigned FILT_CYC = 200,
    parameter int unsigned PULSES   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] hs_short,
    input  logic [1:0] ls_short,
    input  logic       cur_lim,
    input  logic       ot_shut,
    input  logic       ot_cool,
    input  logic       uv,
    input  logic       ol_off_cmp,
    input  logic       pwm_pulse,
    input  logic       fw_seen,
    input  logic       bridge_en,
    input  logic       dir,
    input  logic       ol_dis,
    input  logic       diag_clr,
    input  logic       supply_rst,
    output logic       shutdown_req,
    output logic       err_flag,
    output logic [7:0] status
);
    import hbd_pkg::*;

    localparam int unsigned N_OUT = 2;

    logic [N_OUT-1:0] det_hs, det_ls, scg, scvs;
    logic en_q, dir_q, uv_q, ol_off_q, ot_q, cl_q, ol_on;
    logic en_chg, dir_chg, clr_all, ol_act;

    // Short filters, one per switch
    for (genvar k = 0; k < N_OUT; k++) begin : g_filt
        hbd_short_filter #(.FILT_CYC(FILT_CYC)) u_hs (
            .clk(clk), .rst_n(rst_n), .flag(hs_short[k]), .det(det_hs[k]));
        hbd_short_filter #(.FILT_CYC(FILT_CYC)) u_ls (
            .clk(clk), .rst_n(rst_n), .flag(ls_short[k]), .det(det_ls[k]));
    end

    assign en_chg  = bridge_en != en_q;
    assign dir_chg = dir != dir_q;
    assign clr_all = en_chg || diag_clr || supply_rst;

    hbd_short_latch #(.N_OUT(N_OUT)) u_latch (
        .clk(clk), .rst_n(rst_n), .det_hs(det_hs), .det_ls(det_ls),
        .clr(clr_all), .scg(scg), .scvs(scvs));

    hbd_openload_on #(.PULSES(PULSES)) u_ol (
        .clk(clk), .rst_n(rst_n), .pulse(pwm_pulse), .fw(fw_seen),
        .clr(clr_all || dir_chg), .ol(ol_on));

    // Registered copies of level inputs; enable resets as active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b1;
            dir_q    <= 1'b0;
            uv_q     <= 1'b0;
            ol_off_q <= 1'b0;
        end else begin
            en_q     <= bridge_en;
            dir_q    <= dir;
            uv_q     <= uv;
            ol_off_q <= ol_off_cmp;
        end
    end

    // Overtemperature latch, released only once cooled
    always_ff @(posedge clk) begin
        if (!rst_n)
            ot_q <= 1'b0;
        else if (ot_shut)
            ot_q <= 1'b1;
        else if (ot_cool)
            ot_q <= 1'b0;
    end

    // Current-limit indication; an active limit beats any clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            cl_q <= 1'b0;
        else if (cur_lim)
            cl_q <= 1'b1;
        else if (dir_chg || clr_all)
            cl_q <= 1'b0;
    end

    assign ol_act = !ol_dis && (ol_on || (!en_q && ol_off_q));

    assign shutdown_req = (|scg) || (|scvs) || ot_q || uv_q;
    assign err_flag     = shutdown_req || !en_q;

    always_comb begin
        status        = '0;
        status[ST_EN] = en_q;
        status[ST_OT] = !ot_q;
        status[ST_TV] = 1'b0;
        status[ST_CL] = !cl_q;
        status[3:0]   = fault_code(scg, scvs, uv_q, ol_act);
    end
endmodule

// File: rtl/hbridge_diag_chk.sv
// Property checker for hbridge_diag, attached by bind.
// Assumes the checked ports are sampled on the rising clock edge.
module hbridge_diag_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cur_lim,
    input logic       ot_shut,
    input logic       uv,
    input logic       bridge_en,
    input logic       ol_dis,
    input logic       shutdown_req,
    input logic       err_flag,
    input logic [7:0] status
);
    a_r14_tv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] == 1'b0);

    a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        status[3:0] inside {4'hF, 4'hE, 4'hD, 4'hC, 4'hB, 4'hA, 4'h9,
                            4'h7, 4'h6, 4'h5, 4'h3});

    a_r6_ot_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        ot_shut |=> (shutdown_req && !status[6]));

    a_r7_uv_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        uv |=> shutdown_req);

    a_r11_cl_shown: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lim |=> !status[4]);

    a_r13_disabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_en |=> (err_flag && !status[7]));

    a_r10_ol_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ol_dis |-> status[3:0] != 4'hC);
endmodule

bind hbridge_diag hbridge_diag_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cur_lim(cur_lim), .ot_shut(ot_shut),
    .uv(uv), .bridge_en(bridge_en), .ol_dis(ol_dis),
    .shutdown_req(shutdown_req), .err_flag(err_flag), .status(status));

// File: tb/tb_hbridge_diag.sv
module tb_hbridge_diag;
    localparam int FILT = 200;
    localparam int NP   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] hs_short = '0, ls_short = '0;
    logic cur_lim = 0, ot_shut = 0, ot_cool = 0, uv = 0, ol_off_cmp = 0;
    logic pwm_pulse = 0, fw_seen = 0, bridge_en = 1, dir = 0, ol_dis = 0;
    logic diag_clr = 0, supply_rst = 0;
    logic shutdown_req, err_flag;
    logic [7:0] status;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    hbridge_diag dut (
        .clk(clk), .rst_n(rst_n), .hs_short(hs_short), .ls_short(ls_short),
        .cur_lim(cur_lim), .ot_shut(ot_shut), .ot_cool(ot_cool), .uv(uv),
        .ol_off_cmp(ol_off_cmp), .pwm_pulse(pwm_pulse), .fw_seen(fw_seen),
        .bridge_en(bridge_en), .dir(dir), .ol_dis(ol_dis),
        .diag_clr(diag_clr), .supply_rst(supply_rst),
        .shutdown_req(shutdown_req), .err_flag(err_flag), .status(status));

    // Vector: {hs_short, ls_short, expected status} after FILT edges
    localparam logic [11:0] VEC [9] = '{
        {2'b01, 2'b00, 8'hDE},   // R2 R3 ground short out1
        {2'b10, 2'b00, 8'hDB},   // R3 ground short out2
        {2'b00, 2'b01, 8'hDD},   // R2 R3 supply short out1
        {2'b00, 2'b10, 8'hD7},   // R3 supply short out2
        {2'b11, 2'b00, 8'hDA},   // R3 both ground
        {2'b10, 2'b01, 8'hD9},   // R3 supply1 + ground2
        {2'b01, 2'b10, 8'hD6},   // R3 ground1 + supply2
        {2'b00, 2'b11, 8'hD5},   // R3 both supply
        {2'b01, 2'b01, 8'hDE}    // R4 same output, ground wins
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic pulse_once(input logic fw);
        pwm_pulse = 1'b1; fw_seen = fw;
        tick(1);
        pwm_pulse = 1'b0; fw_seen = 1'b0;
        tick(1);
    endtask

    task automatic clr_pulse();
        diag_clr = 1'b1; tick(1); diag_clr = 1'b0; tick(1);
    endtask

    initial begin
        #2_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog got=hung exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 status", status, 8'hDF);
        chk("R1 flags", {6'd0, shutdown_req, err_flag}, 8'h00);

        // Table walk over short combinations
        for (int i = 0; i < 9; i++) begin
            hs_short = VEC[i][11:10];
            ls_short = VEC[i][9:8];
            tick(FILT);
            hs_short = '0; ls_short = '0;
            tick(2);
            chk("R3 R4 code", status, VEC[i][7:0]);
            chk("R5 shutdown held", {7'd0, shutdown_req}, 8'h01);
            clr_pulse();
            chk("R5 diag_clr", status, 8'hDF);
        end

        // R2 run one short of the filter time
        hs_short = 2'b01; tick(FILT - 1); hs_short = '0; tick(2);
        chk("R2 short run", status, 8'hDF);

        // R4 first kind wins over a later other kind
        hs_short = 2'b01; tick(FILT); hs_short = '0;
        ls_short = 2'b01; tick(FILT); ls_short = '0; tick(1);
        chk("R4 first wins", status, 8'hDE);

        // R5 enable toggle clears
        bridge_en = 1'b0; tick(1); bridge_en = 1'b1; tick(2);
        chk("R5 enable reset", status, 8'hDF);

        // R5 supply reset clears
        ls_short = 2'b10; tick(FILT); ls_short = '0; tick(1);
        chk("R5 latched", status, 8'hD7);
        supply_rst = 1'b1; tick(1); supply_rst = 1'b0; tick(1);
        chk("R5 supply_rst", status, 8'hDF);

        // R6 overtemperature latch
        ot_shut = 1'b1; tick(1); ot_shut = 1'b0; tick(3);
        chk("R6 ot latched", status, 8'h9F);
        chk("R6 shutdown", {7'd0, shutdown_req}, 8'h01);
        ot_cool = 1'b1; tick(1); ot_cool = 1'b0; tick(1);
        chk("R6 ot released", status, 8'hDF);

        // R7 undervoltage not latched
        uv = 1'b1; tick(1);
        chk("R7 uv code", status, 8'hD3);
        chk("R7 uv shutdown", {6'd0, shutdown_req, err_flag}, 8'h03);
        uv = 1'b0; tick(1);
        chk("R7 uv gone", status, 8'hDF);

        // R8 open load while switching
        for (int p = 0; p < NP - 1; p++) pulse_once(1'b0);
        chk("R8 four misses", status, 8'hDF);
        pulse_once(1'b0);
        chk("R8 five misses", status, 8'hDC);
        // R12 undervoltage above open load
        uv = 1'b1; tick(1);
        chk("R12 uv over ol", status, 8'hD3);
        uv = 1'b0; tick(1);
        for (int p = 0; p < NP - 1; p++) pulse_once(1'b1);
        chk("R8 four freewheels", status, 8'hDC);
        pulse_once(1'b1);
        chk("R8 auto clear", status, 8'hDF);
        for (int p = 0; p < NP; p++) pulse_once(1'b0);
        chk("R8 set again", status, 8'hDC);
        // R10 mask while switching
        ol_dis = 1'b1; tick(1);
        chk("R10 mask on", status, 8'hDF);
        ol_dis = 1'b0;
        dir = 1'b1; tick(2);
        chk("R8 dir clears", status, 8'hDF);

        // R12 short above undervoltage
        hs_short = 2'b10; tick(FILT); hs_short = '0;
        uv = 1'b1; tick(1);
        chk("R12 short over uv", status, 8'hDB);
        uv = 1'b0; clr_pulse();

        // R9 R13 open load while off
        bridge_en = 1'b0; ol_off_cmp = 1'b1; tick(2);
        chk("R9 off open load", status, 8'h5C);
        chk("R13 disabled flags", {6'd0, shutdown_req, err_flag}, 8'h01);
        ol_dis = 1'b1; tick(1);
        chk("R10 mask off", status, 8'h5F);
        ol_dis = 1'b0; ol_off_cmp = 1'b0; bridge_en = 1'b1; tick(2);
        chk("R13 enabled", status, 8'hDF);

        // R11 current limit indication
        cur_lim = 1'b1; tick(1); cur_lim = 1'b0; tick(3);
        chk("R11 cl held", status, 8'hCF);
        dir = 1'b0; tick(2);
        chk("R11 dir clears", status, 8'hDF);
        chk("R14 tv", {7'd0, status[5]}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule